// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block keeps the status byte of a serial non-volatile memory and rules on every write request the memory sees. It holds a write-enable latch, a two-bit block-protect code, a protect-enable bit, and it shows a busy flag that it takes from outside. The serial front end feeds it decoded instruction strobes, a chip-select rising event and the target write address. The block returns the assembled status byte and two permit signals. One permit covers the memory array and the other covers the status register.

A write to the array is allowed only when the enable latch is set and the address lies outside the protected region. The protected region is a fixed fraction at the top of the address space, picked by the block-protect code. A write to the status register also needs the latch to be set. On top of that, the register is locked by hardware whenever the protect-enable bit is set and the active-low protect pin is driven low. If that lock appears while a status write is still waiting for chip select to rise, the write is dropped. Once the write has been committed, the pin no longer affects it. While busy is asserted, no instruction strobe is accepted.

Top module: `wp_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 while busy is low, and both permits are low.
- R2: The status byte is laid out as follows: bit 7 protect-enable, bits 6..4 always 0, bit 3 and bit 2 the protect code (high bit first), bit 1 the enable latch, and bit 0 busy. Bit 0 follows the busy input in the same cycle.
- R3: The enable latch is set one cycle after a cs_rise pulse, and only when an accepted wren_stb came before that pulse within the same selection. A cs_rise pulse with no such strobe leaves the latch at 0.
- R4: An accepted wrdi_stb clears the enable latch on the next cycle.
- R5: A cycle_done pulse clears the enable latch on the next cycle.
- R6: While the enable latch is 0, array_wr_ok and sr_wr_ok are both 0.
- R7: When the enable latch is 1, the protect code decides array_wr_ok. Code 00 permits every address. Code 01 refuses the top quarter (0x1800..0x1FFF at 13 address bits). Code 10 refuses the top half (0x1000..0x1FFF). Code 11 refuses every address.
- R8: A status write takes its byte from wrsr_stb and commits it on the following cs_rise. Only bits 7, 3 and 2 change, and they never change at any other time.
- R9: When protect-enable is 1 and wp_n is 0, sr_wr_ok is 0 and a status write is refused.
- R10: If the lock of R9 appears between wrsr_stb and cs_rise, the status write is dropped. Driving wp_n low after the commit leaves the stored bits unchanged.
- R11: While busy is 1, wren_stb, wrdi_stb and wrsr_stb are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wren_stb | input | 1 | Enable-writes opcode fully received |
| wrdi_stb | input | 1 | Disable-writes opcode fully received |
| wrsr_stb | input | 1 | Status-write data byte received |
| wrsr_byte | input | 8 | Status byte to be written |
| cs_rise | input | 1 | Chip select went high (one-cycle pulse) |
| cycle_done | input | 1 | An internal write cycle finished |
| busy | input | 1 | Internal write cycle in progress |
| wp_n | input | 1 | Hardware protect pin, active low |
| wr_addr | input | ADDR_W | Array address of the pending write |
| status | output | 8 | Status byte |
| array_wr_ok | output | 1 | Array write permitted at wr_addr |
| sr_wr_ok | output | 1 | Status register write permitted |

## Verification
The bench builds the block with ADDR_W at 13, so the address space is 8K. At that width the quarter and half boundaries sit at 0x1800 and 0x1000, and both sides of each boundary can be probed directly. A table of protect codes and addresses covers every code, including the last unprotected address and the first protected one. Directed sequences then cover the latch arming order, a lock that appears mid-write against one that appears after commit, and strobes sent while busy.

// File: rtl/wp_pkg.sv
package wp_pkg;
   localparam int SR_W     = 8;
   localparam int POS_PEN  = 7;
   localparam int POS_BPH  = 3;
   localparam int POS_BPL  = 2;
   localparam int POS_LAT  = 1;
   localparam int POS_BSY  = 0;

   typedef struct packed {
      logic       pen;
      logic [1:0] bp;
   } nv_bits_t;

   function automatic nv_bits_t take_nv(input logic [SR_W-1:0] b);
      nv_bits_t r;
      r.pen = b[POS_PEN];
      r.bp  = {b[POS_BPH], b[POS_BPL]};
      return r;
   endfunction
endpackage

// File: rtl/wel_ctrl.sv
module wel_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wren_stb,
   input  logic wrdi_stb,
   input  logic cs_rise,
   input  logic cycle_done,
   input  logic busy,
   output logic wel
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (cs_rise) begin
         armed <= 1'b0;
      end else if (wren_stb && !busy) begin
         armed <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
      end else if (cycle_done || (wrdi_stb && !busy)) begin
         wel <= 1'b0;
      end else if (cs_rise && armed) begin
         wel <= 1'b1;
      end
   end
endmodule

// File: rtl/sr_store.sv
module sr_store
   import wp_pkg::*;
#(
   parameter logic       RST_PEN = 1'b0,
   parameter logic [1:0] RST_BP  = 2'b00
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_stb,
   input  logic [SR_W-1:0] wr_byte,
   input  logic            cs_rise,
   input  logic            busy,
   input  logic            wel,
   input  logic            wp_n,
   output nv_bits_t        nv,
   output logic            sr_ok
);
   logic     pend;
   nv_bits_t staged;
   logic     hw_lock;

   assign hw_lock = nv.pen && !wp_n;
   assign sr_ok   = wel && !hw_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         staged <= '0;
      end else if (cs_rise || hw_lock) begin
         pend <= 1'b0;
      end else if (wr_stb && !busy && sr_ok) begin
         pend   <= 1'b1;
         staged <= take_nv(wr_byte);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv.pen <= RST_PEN;
         nv.bp  <= RST_BP;
      end else if (cs_rise && pend && sr_ok) begin
         nv <= staged;
      end
   end
endmodule

// File: rtl/range_guard.sv
module range_guard #(
   parameter int ADDR_W = 13
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        bp,
   input  logic              wel,
   output logic              ok
);
   localparam int MSB = ADDR_W - 1;
   logic in_quarter, in_half, hit;

   generate
      if (ADDR_W < 2) begin : g_bad
         $error("range_guard: ADDR_W must be at least 2");
         assign in_quarter = 1'b0;
         assign in_half    = 1'b0;
      end else begin : g_dec
         assign in_quarter = &addr[MSB -: 2];
         assign in_half    = addr[MSB];
      end
   endgenerate

   always_comb begin
      unique case (bp)
         2'b00:   hit = 1'b0;
         2'b01:   hit = in_quarter;
         2'b10:   hit = in_half;
         default: hit = 1'b1;
      endcase
   end

   assign ok = wel && !hit;
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
   import wp_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wren_stb,
   input  logic              wrdi_stb,
   input  logic              wrsr_stb,
   input  logic [7:0]        wrsr_byte,
   input  logic              cs_rise,
   input  logic              cycle_done,
   input  logic              busy,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        status,
   output logic              array_wr_ok,
   output logic              sr_wr_ok
);
   logic     wel;
   nv_bits_t nv;

   wel_ctrl u_wel (
      .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
      .cs_rise(cs_rise), .cycle_done(cycle_done), .busy(busy), .wel(wel)
   );

   sr_store #(.RST_PEN(1'b0), .RST_BP(2'b00)) u_sr (
      .clk(clk), .rst_n(rst_n), .wr_stb(wrsr_stb), .wr_byte(wrsr_byte),
      .cs_rise(cs_rise), .busy(busy), .wel(wel), .wp_n(wp_n),
      .nv(nv), .sr_ok(sr_wr_ok)
   );

   range_guard #(.ADDR_W(ADDR_W)) u_rng (
      .addr(wr_addr), .bp(nv.bp), .wel(wel), .ok(array_wr_ok)
   );

   always_comb begin
      status          = '0;
      status[POS_PEN] = nv.pen;
      status[POS_BPH] = nv.bp[1];
      status[POS_BPL] = nv.bp[0];
      status[POS_LAT] = wel;
      status[POS_BSY] = busy;
   end
endmodule

// File: rtl/wp_status_guard_chk.sv
module wp_status_guard_chk #(
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wrdi_stb,
   input logic              cs_rise,
   input logic              cycle_done,
   input logic              busy,
   input logic              wp_n,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        status,
   input logic              array_wr_ok,
   input logic              sr_wr_ok
);
   // R2
   rdy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] == busy && status[6:4] == 3'b000);
   // R3
   latch_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> $past(cs_rise));
   // R4
   wrdi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrdi_stb && !busy) |=> !status[1]);
   // R5
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |=> !status[1]);
   // R6
   no_latch_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status[1] |-> (!array_wr_ok && !sr_wr_ok));
   // R7
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[3:2] == 2'b11) |-> !array_wr_ok);
   // R8
   nv_only_on_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_rise |=> $stable({status[7], status[3:2]}));
   // R9
   hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && !wp_n) |-> !sr_wr_ok);
endmodule

bind wp_status_guard wp_status_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wrdi_stb(wrdi_stb), .cs_rise(cs_rise),
   .cycle_done(cycle_done), .busy(busy), .wp_n(wp_n), .wr_addr(wr_addr),
   .status(status), .array_wr_ok(array_wr_ok), .sr_wr_ok(sr_wr_ok)
);

// File: tb/test_wp_status_guard.sv
module test_wp_status_guard;
   localparam int AW = 13;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wren_stb = 0, wrdi_stb = 0, wrsr_stb = 0, cs_rise = 0;
   logic cycle_done = 0, busy = 0, wp_n = 1;
   logic [7:0] wrsr_byte = 8'h00;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0] status;
   logic array_wr_ok, sr_wr_ok;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wp_status_guard #(.ADDR_W(AW)) i_wp_status_guard (
      .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
      .wrsr_stb(wrsr_stb), .wrsr_byte(wrsr_byte), .cs_rise(cs_rise),
      .cycle_done(cycle_done), .busy(busy), .wp_n(wp_n), .wr_addr(wr_addr),
      .status(status), .array_wr_ok(array_wr_ok), .sr_wr_ok(sr_wr_ok)
   );

   // {bp[1:0], addr[12:0], expected permit}
   localparam logic [15:0] VEC [0:11] = '{
      {2'b00, 13'h1FFF, 1'b1}, {2'b01, 13'h17FF, 1'b1}, {2'b01, 13'h1800, 1'b0},
      {2'b01, 13'h1FFF, 1'b0}, {2'b10, 13'h0FFF, 1'b1}, {2'b10, 13'h1000, 1'b0},
      {2'b11, 13'h0000, 1'b0}, {2'b11, 13'h1234, 1'b0}, {2'b00, 13'h0000, 1'b1},
      {2'b10, 13'h1FFF, 1'b0}, {2'b01, 13'h0000, 1'b1}, {2'b00, 13'h1800, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_wren();
      wren_stb = 1; @(negedge clk); wren_stb = 0;
      cs_rise = 1;  @(negedge clk); cs_rise = 0;
   endtask

   task automatic write_sr(input logic [7:0] b);
      wrsr_stb = 1; wrsr_byte = b; @(negedge clk); wrsr_stb = 0;
      cs_rise = 1; @(negedge clk); cs_rise = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", status, 8'h00);
      chk("R1 permits", {array_wr_ok, sr_wr_ok}, 2'b00);
      // R6 denied before enable
      wr_addr = 13'h0010; #1;
      chk("R6 deny", {array_wr_ok, sr_wr_ok}, 2'b00);
      // R3 cs_rise without opcode leaves latch clear
      cs_rise = 1; @(negedge clk); cs_rise = 0;
      chk("R3 bare cs", status[1], 1'b0);
      // R3 strobe without cs_rise does not set latch yet
      wren_stb = 1; @(negedge clk); wren_stb = 0; @(negedge clk);
      chk("R3 no cs yet", status[1], 1'b0);
      cs_rise = 1; @(negedge clk); cs_rise = 0;
      chk("R3 armed set", status[1], 1'b1);
      // R4
      wrdi_stb = 1; @(negedge clk); wrdi_stb = 0;
      chk("R4 wrdi", status[1], 1'b0);
      // R5
      pulse_wren();
      cycle_done = 1; @(negedge clk); cycle_done = 0;
      chk("R5 done", status[1], 1'b0);

      // R7 table
      for (int i = 0; i < 12; i++) begin
         pulse_wren();
         write_sr({4'b0000, VEC[i][15:14], 2'b00});
         wr_addr = VEC[i][13:1]; #1;
         chk("R7 range", array_wr_ok, VEC[i][0]);
      end

      // R8 only bits 7,3,2 change; others forced
      pulse_wren();
      write_sr(8'h73);
      chk("R8 mask", status, 8'h02);
      pulse_wren();
      write_sr(8'hFF);
      chk("R8 set", status, 8'h8E);
      // R2 busy mirrors to bit 0 same cycle
      busy = 1; #1;
      chk("R2 rdy", status, 8'h8F);
      // R11 strobes ignored while busy
      wrdi_stb = 1; @(negedge clk); wrdi_stb = 0;
      write_sr(8'h00);
      chk("R11 busy ignore", status, 8'h8F);
      busy = 0;
      cycle_done = 1; @(negedge clk); cycle_done = 0;
      busy = 1; pulse_wren(); busy = 0; #1;
      chk("R11 wren ignored", status[1], 1'b0);

      // R9 hardware lock: pen=1, wp_n low
      pulse_wren();
      wp_n = 0; #1;
      chk("R9 sr lock", sr_wr_ok, 1'b0);
      write_sr(8'h00);
      chk("R9 refused", status, 8'h8E);
      wp_n = 1; #1;
      chk("R9 unlock", sr_wr_ok, 1'b1);

      // R10 lock mid-write drops it
      wrsr_stb = 1; wrsr_byte = 8'h04; @(negedge clk); wrsr_stb = 0;
      wp_n = 0; @(negedge clk);
      wp_n = 1; cs_rise = 1; @(negedge clk); cs_rise = 0;
      chk("R10 cancel", status, 8'h8E);
      // R10 lock after commit has no effect
      write_sr(8'h84);
      wp_n = 0; @(negedge clk); @(negedge clk);
      chk("R10 after commit", status, 8'h86);
      wp_n = 1;

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule